// File: doc/BRIEF.md
# Cache Tag Store with Match Comparator

This block is the tag half of a direct-mapped cache. An index selects one word of a synchronous tag array. The tag byte on the input is either stored at that index or compared with what is already there. The result appears as a match flag. There is also an active-high `pull_low` output, which stands in for an open-drain match line. Several stores can share that line, and the line is high only when every store reports a hit. Two stores side by side therefore compare a tag twice as wide.

Four active-low controls choose the mode: chip select, write enable, output enable and clear. The clear input, and the power-on reset, start a sequenced sweep. The sweep writes zero to one word per clock and keeps `busy` high until every word is zero. While the sweep runs, every request is ignored and match stays high.

The default build holds 2048 words of 8 bits. Setting `INDEX_W` to 13 gives the full 8K-word arrangement, in which 13 index bits plus 8 tag bits cover a 21-bit line address.

All results are registered. Read data, read-valid and the match result all describe the request that was presented in the previous cycle.

Top module: `tag_store`

## Requirements
- R1: When `cs_n`=0, `we_n`=0, `clr_n`=1 and `busy`=0, the rising edge stores `tag_in` at `addr`, whatever the value of `oe_n`.
- R2: When `cs_n`=0, `we_n`=1, `oe_n`=0, `clr_n`=1 and `busy`=0, the next cycle shows `rd_vld`=1 and `rd_data` equal to the stored word. In every other cycle `rd_vld`=0 and `rd_data`=0.
- R3: When `cs_n`=0, `we_n`=1, `oe_n`=1, `clr_n`=1 and `busy`=0 (compare mode), the next cycle shows `match`=1 if the stored word equals `tag_in` and `match`=0 if it does not. `pull_low` is always the inverse of `match`.
- R4: The cycle after a read, a write or a deselect request, `match` is 1 and `pull_low` is 0.
- R5: With `cs_n`=1 the array is not changed, and the next cycle shows `rd_vld`=0 and `match`=1.
- R6: `clr_n`=0 at a rising edge sets `busy` from the next cycle and restarts the sweep at word 0. After `clr_n` returns high, `busy` stays high for exactly 2^`INDEX_W` cycles. After that, every word reads zero.
- R7: During and after reset, `busy`=1, `match`=1, `pull_low`=0, `rd_vld`=0 and `rd_data`=0. The sweep then runs for 2^`INDEX_W` cycles, so every tag is zero before the first compare.
- R8: While `busy`=1, write, read and compare requests are ignored and `match` stays 1.
- R9: When several stores share an index and the shared line is formed as the NOR of their `pull_low` outputs, the line is 1 exactly when every store's slice of a wider tag hits.
- R10: A compare presented in the cycle right after a write to the same word sees the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; starts the zeroing sweep |
| clr_n | input | 1 | Active-low clear request; restarts the sweep |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable (read) |
| addr | input | INDEX_W | Word index |
| tag_in | input | TAG_W | Tag byte to store or compare |
| rd_data | output | TAG_W | Stored word of the previous read, else zero |
| rd_vld | output | 1 | rd_data holds a read result |
| match | output | 1 | Low only after a compare that missed |
| pull_low | output | 1 | Active-high request to pull the shared match line low |
| busy | output | 1 | Zeroing sweep in progress |

## Verification
The hardest situation to reach from the ports is a request that arrives while the sweep is running, because the sweep hides any effect such a request might have. The bench holds write requests to word 0 for the whole sweep. Word 0 has already been zeroed at that point, so any write that got through would survive. The bench then reads word 0 back once `busy` falls. It also holds a compare against a non-zero tag throughout the power-on sweep and watches that `match` never drops. Two stores share one set of controls to form a wired 16-bit tag, and the bench makes misses in one slice, the other slice and both.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  typedef enum logic [2:0] {
    M_CLEAR,
    M_DESEL,
    M_WRITE,
    M_READ,
    M_CMP
  } mode_e;

  // Priority: clear/busy, then deselect, then write, then read, else compare
  function automatic mode_e decode_mode(input logic clr_n, input logic busy,
                                        input logic cs_n, input logic we_n,
                                        input logic oe_n);
    if (!clr_n || busy) return M_CLEAR;
    if (cs_n)           return M_DESEL;
    if (!we_n)          return M_WRITE;
    if (!oe_n)          return M_READ;
    return M_CMP;
  endfunction
endpackage

// File: rtl/tag_sweep.sv
module tag_sweep #(
  parameter int INDEX_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  output logic               busy,
  output logic               wr_en,
  output logic [INDEX_W-1:0] wr_idx
);
  localparam logic [INDEX_W-1:0] LAST = '1;

  logic [INDEX_W-1:0] ptr_q;
  logic               busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (!clr_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
    end else if (busy_q) begin
      ptr_q <= ptr_q + 1'b1;
      if (ptr_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy   = busy_q;
  assign wr_en  = busy_q && clr_n;
  assign wr_idx = ptr_q;
endmodule

// File: rtl/tag_array.sv
module tag_array #(
  parameter int INDEX_W = 11,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [INDEX_W-1:0] waddr,
  input  logic [TAG_W-1:0]   wdata,
  input  logic [INDEX_W-1:0] raddr,
  output logic [TAG_W-1:0]   rdata
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tag_store.sv
module tag_store
  import tag_store_pkg::*;
#(
  parameter int INDEX_W = 11,
  parameter int TAG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_n,
  input  logic               cs_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [INDEX_W-1:0] addr,
  input  logic [TAG_W-1:0]   tag_in,
  output logic [TAG_W-1:0]   rd_data,
  output logic               rd_vld,
  output logic               match,
  output logic               pull_low,
  output logic               busy
);
  mode_e              mode;
  logic               sweep_wr;
  logic [INDEX_W-1:0] sweep_idx;
  logic               arr_we;
  logic [INDEX_W-1:0] arr_waddr;
  logic [TAG_W-1:0]   arr_wdata;
  logic [TAG_W-1:0]   word_q;
  logic [TAG_W-1:0]   tag_q;
  logic               cmp_q;
  logic               rd_q;
  logic               hit;

  tag_sweep #(.INDEX_W(INDEX_W)) u_sweep (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .busy   (busy),
    .wr_en  (sweep_wr),
    .wr_idx (sweep_idx)
  );

  assign mode      = decode_mode(clr_n, busy, cs_n, we_n, oe_n);
  assign arr_we    = sweep_wr || (mode == M_WRITE);
  assign arr_waddr = sweep_wr ? sweep_idx : addr;
  assign arr_wdata = sweep_wr ? '0 : tag_in;

  tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (addr),
    .rdata (word_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= 1'b0;
      rd_q  <= 1'b0;
      tag_q <= '0;
    end else begin
      cmp_q <= (mode == M_CMP);
      rd_q  <= (mode == M_READ);
      tag_q <= tag_in;
    end
  end

  assign hit      = (word_q == tag_q);
  assign pull_low = cmp_q && !hit;
  assign match    = !pull_low;
  assign rd_vld   = rd_q;
  assign rd_data  = rd_q ? word_q : '0;
endmodule

// File: rtl/tag_store_chk.sv
module tag_store_chk #(
  parameter int INDEX_W = 11,
  parameter int TAG_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr_n,
  input logic               cs_n,
  input logic               we_n,
  input logic               oe_n,
  input logic [TAG_W-1:0]   rd_data,
  input logic               rd_vld,
  input logic               match,
  input logic               pull_low,
  input logic               busy
);
  wire idle_ok = clr_n && !busy;

  p_busy_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (match && !pull_low));

  p_clear_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> busy);

  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && idle_ok) |=> (match && !rd_vld));

  p_write_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> match);

  p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ok && !cs_n && we_n && !oe_n) |=> rd_vld);

  p_pull_only_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> $past(idle_ok && !cs_n && we_n && oe_n));

  p_no_rd_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_vld && pull_low));
endmodule

bind tag_store tag_store_chk #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_n    (clr_n),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .rd_data  (rd_data),
  .rd_vld   (rd_vld),
  .match    (match),
  .pull_low (pull_low),
  .busy     (busy)
);

// File: tb/tag_store_tb.sv
`timescale 1ns/1ps
module tag_store_tb;
  localparam int IW    = 11;
  localparam int TW    = 8;
  localparam int DEPTH = 1 << IW;

  logic clk = 1'b0;
  logic rst_n, clr_n, cs_n, we_n, oe_n;
  logic [IW-1:0] addr;
  logic [TW-1:0] tag_lo, tag_hi;
  logic [TW-1:0] rd_lo, rd_hi;
  logic vld_lo, vld_hi, m_lo, m_hi, pl_lo, pl_hi, busy_lo, busy_hi;
  wire  wired = ~(pl_lo | pl_hi);

  logic [TW-1:0] mod_lo [DEPTH];
  logic [TW-1:0] mod_hi [DEPTH];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  tag_store #(.INDEX_W(IW), .TAG_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .tag_in(tag_lo), .rd_data(rd_lo),
    .rd_vld(vld_lo), .match(m_lo), .pull_low(pl_lo), .busy(busy_lo));

  tag_store #(.INDEX_W(IW), .TAG_W(TW)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .tag_in(tag_hi), .rd_data(rd_hi),
    .rd_vld(vld_hi), .match(m_hi), .pull_low(pl_hi), .busy(busy_hi));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic model_zero();
    for (int i = 0; i < DEPTH; i++) begin
      mod_lo[i] = '0;
      mod_hi[i] = '0;
    end
  endtask

  task automatic wr(input int a, input logic [TW-1:0] lo, input logic [TW-1:0] hi);
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = IW'(a); tag_lo = lo; tag_hi = hi;
    step();
    mod_lo[a] = lo; mod_hi[a] = hi;
    check(m_lo && !pl_lo && !vld_lo, "R4", "match after write", {vld_lo, m_lo}, 1);
    idle();
  endtask

  task automatic rd(input int a, input string req);
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = IW'(a);
    step();
    check(vld_lo && rd_lo == mod_lo[a], req, "read lo", rd_lo, mod_lo[a]);
    check(vld_hi && rd_hi == mod_hi[a], req, "read hi", rd_hi, mod_hi[a]);
    check(m_lo && m_hi, "R4", "match during read", {m_hi, m_lo}, 3);
    idle();
  endtask

  task automatic cmp(input int a, input logic [TW-1:0] lo, input logic [TW-1:0] hi,
                     input string req);
    bit e_lo, e_hi;
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = IW'(a); tag_lo = lo; tag_hi = hi;
    step();
    e_lo = (mod_lo[a] == lo);
    e_hi = (mod_hi[a] == hi);
    check(m_lo == e_lo && pl_lo == !e_lo, req, "compare lo", {pl_lo, m_lo}, {!e_lo, e_lo});
    check(m_hi == e_hi && pl_hi == !e_hi, req, "compare hi", {pl_hi, m_hi}, {!e_hi, e_hi});
    check(wired == (e_lo && e_hi), "R9", "wired line", wired, e_lo && e_hi);
    idle();
  endtask

  task automatic t_reset_sweep();
    int n = 0;
    bit held = 1'b1;
    rst_n = 1'b0; clr_n = 1'b1; idle(); addr = '0; tag_lo = '0; tag_hi = '0;
    repeat (3) @(negedge clk);
    check(busy_lo && m_lo && !pl_lo && !vld_lo && rd_lo == 0, "R7", "reset state",
          {busy_lo, m_lo, pl_lo, vld_lo}, 4'b1100);
    rst_n = 1'b1;
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = IW'(5); tag_lo = 8'h5A; tag_hi = 8'hA5;
    while (busy_lo) begin
      step();
      n++;
      if (!m_lo || pl_lo || vld_lo) held = 1'b0;
    end
    idle();
    model_zero();
    check(n == DEPTH, "R7", "power-on sweep length", n, DEPTH);
    check(held, "R8", "match high while sweeping", held, 1);
  endtask

  task automatic t_zero_after_clear();
    cmp(0, 8'h00, 8'h00, "R7");
    cmp(DEPTH-1, 8'h00, 8'h00, "R7");
    cmp(5, 8'h5A, 8'hA5, "R8");
    cmp(100, 8'h01, 8'h00, "R3");
  endtask

  task automatic t_write_read();
    wr(0, 8'h11, 8'h22);
    wr(DEPTH-1, 8'hFE, 8'h7F);
    wr(300, 8'h80, 8'h01);
    rd(0, "R1");
    rd(DEPTH-1, "R1");
    rd(300, "R2");
    step();
    check(!vld_lo && rd_lo == 0, "R2", "idle read output", {vld_lo, rd_lo}, 0);
  endtask

  task automatic t_compare_patterns();
    cmp(300, 8'h80, 8'h01, "R3");
    cmp(300, 8'h81, 8'h01, "R3");
    cmp(300, 8'h80, 8'h03, "R3");
    cmp(300, 8'h7F, 8'hFE, "R3");
    cmp(DEPTH-1, 8'hFE, 8'h7F, "R3");
  endtask

  task automatic t_back_to_back();
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = IW'(77); tag_lo = 8'hC3; tag_hi = 8'h3C;
    step();
    mod_lo[77] = 8'hC3; mod_hi[77] = 8'h3C;
    cmp(77, 8'hC3, 8'h3C, "R10");
  endtask

  task automatic t_write_priority();
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = IW'(9); tag_lo = 8'h99; tag_hi = 8'h66;
    step();
    mod_lo[9] = 8'h99; mod_hi[9] = 8'h66;
    check(!vld_lo && m_lo, "R1", "write wins over read", {vld_lo, m_lo}, 1);
    idle();
    rd(9, "R1");
  endtask

  task automatic t_deselect();
    cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = IW'(0); tag_lo = 8'hEE; tag_hi = 8'hEE;
    step();
    check(m_lo && !pl_lo && !vld_lo, "R5", "deselect outputs", {pl_lo, vld_lo, m_lo}, 1);
    idle();
    rd(0, "R5");
  endtask

  task automatic t_clear();
    int n = 0;
    bit held = 1'b1;
    clr_n = 1'b0;
    step();
    check(busy_lo && m_lo, "R6", "busy on clear", {busy_lo, m_lo}, 3);
    step();
    clr_n = 1'b1;
    cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = '0; tag_lo = 8'hFF; tag_hi = 8'hFF;
    while (busy_lo) begin
      step();
      n++;
      if (!m_lo) held = 1'b0;
    end
    idle();
    model_zero();
    check(n == DEPTH, "R6", "clear sweep length", n, DEPTH);
    check(held, "R8", "match high during clear", held, 1);
    rd(0, "R8");
    rd(300, "R6");
    rd(DEPTH-1, "R6");
    cmp(9, 8'h00, 8'h00, "R6");
  endtask

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_sweep();
    t_zero_after_clear();
    t_write_read();
    t_compare_patterns();
    t_back_to_back();
    t_write_priority();
    t_deselect();
    t_clear();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule